// File: doc/BRIEF.md
# Credit-Based Transmit Flow Gate

This block guards the transmit side of a packet link for a single traffic class. It keeps two credit pools granted by the far receiver. The header pool is charged one credit per packet. The data pool is charged one credit per DWORD of payload. A packet is allowed out only when both pools can cover it, so the receiver's buffers can never be overrun.

After reset the gate is closed. An init-credit message loads both limits and opens it. The value all ones in either init field marks that pool as unlimited, and an unlimited pool never blocks. Credit-return messages add credits back, and they may arrive in the same cycle as a grant. A pending request is answered by `grant` in the same cycle. The requester holds the request until it sees `grant`.

Top module: `tx_credit_gate`

## Requirements
- R1: After reset, and until the first init-credit message has been taken, `grant` stays low whatever the request inputs do, and `ovf_err` is low.
- R2: When `init_valid` is high at a clock edge, both pools load `init_hdr` and `init_data`, and the gate is open from the next cycle onward.
- R3: `grant` is high in a cycle exactly when `req_valid` is high, the gate is open, `init_valid` is low, the header pool holds at least 1, and the data pool holds at least the packet's DWORD need.
- R4: On a granted packet, the header pool loses 1 and the data pool loses the DWORD need, effective from the next cycle.
- R5: With `req_has_data` high, a `req_len` of 0 means a payload of 1024 DWORDs; any other value means `req_len` DWORDs.
- R6: A packet with `req_has_data` low needs, and consumes, zero data credits.
- R7: An init field of all ones makes that pool unlimited: it never blocks a grant and is not changed by grants or returns until the next init.
- R8: When `upd_valid` is high, `upd_hdr` and `upd_data` are added to the finite pools. If a grant happens in the same cycle, each pool changes by the returned amount minus the consumed amount.
- R9: If a return would carry a finite pool above its all-ones maximum, that pool saturates at the maximum and `ovf_err` is high for the following cycle.
- R10: While credits are short, `grant` stays low. The held request is granted in the first cycle its needs are covered.
- R11: In a cycle with `init_valid` high, `grant` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| init_valid | input | 1 | Init-credit message present |
| init_hdr | input | HDR_W | Initial header credits (all ones = unlimited) |
| init_data | input | DATA_W | Initial data credits in DWORDs (all ones = unlimited) |
| upd_valid | input | 1 | Credit-return message present |
| upd_hdr | input | HDR_W | Header credits returned |
| upd_data | input | DATA_W | Data credits returned |
| req_valid | input | 1 | Packet waiting to be sent |
| req_has_data | input | 1 | Packet carries a payload |
| req_len | input | LEN_W | Payload length in DWORDs (0 = 1024) |
| grant | output | 1 | Packet may go this cycle |
| ovf_err | output | 1 | A return overflowed a finite pool in the previous cycle |

## Verification
The assertions assume that a requester keeps `req_valid` high until it sees `grant`. They also assume that returns are only sent once the link is up. The bench keeps to both assumptions. Its driver holds each pending packet unchanged until the reference model says it is granted. Its stimulus is mostly small returns, with a rare large return that deliberately overflows a pool and an occasional re-initialisation. The init values include the all-ones code, so the unlimited path is exercised.

// File: rtl/txcg_pkg.sv
// Package: shared default widths for the transmit credit gate.
// Assumes: the data pool is wide enough to hold the largest packet need.
package txcg_pkg;
    localparam int HDR_W_DEF  = 8;   // header credit field width
    localparam int DATA_W_DEF = 12;  // data credit field width
    localparam int LEN_W_DEF  = 10;  // payload length field width
endpackage

// File: rtl/txcg_demand.sv
// Module: turns a packet's length field into its data credit need.
// Assumes: OUT_W > LEN_W, so that 2**LEN_W fits in the output.
module txcg_demand #(
    parameter int LEN_W = txcg_pkg::LEN_W_DEF,
    parameter int OUT_W = txcg_pkg::DATA_W_DEF
) (
    input  logic [LEN_W-1:0] len,
    input  logic             has_data,
    output logic [OUT_W-1:0] need
);
    localparam logic [OUT_W-1:0] FULL_LEN = OUT_W'(1) << LEN_W;

    // Purpose: a zero length means the full field range; no payload means no need.
    always_comb begin
        if (!has_data)
            need = '0;
        else if (len == '0)
            need = FULL_LEN;
        else
            need = OUT_W'(len);
    end
endmodule

// File: rtl/txcg_pool.sv
// Module: one credit pool. It loads on init, is charged on a grant, and is
// refilled on a return. The count saturates at all ones.
// Assumes: `take` is only high when `enough` is high.
module txcg_pool #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         init_valid,
    input  logic [W-1:0] init_val,
    input  logic         take,
    input  logic [W-1:0] need,
    input  logic         ret_valid,
    input  logic [W-1:0] ret_amt,
    output logic [W-1:0] avail,
    output logic         unlimited,
    output logic         enough,
    output logic         ovf
);
    logic [W:0]   sum;
    logic         over;
    logic [W-1:0] next_cnt;

    // Purpose: this cycle's sufficiency test for the pending packet.
    assign enough = unlimited || (avail >= need);

    // Purpose: the net count after the charge and the refill, with saturation.
    always_comb begin
        sum      = {1'b0, avail} - {1'b0, (take ? need : W'(0))}
                                 + {1'b0, (ret_valid ? ret_amt : W'(0))};
        over     = sum[W];
        next_cnt = over ? {W{1'b1}} : sum[W-1:0];
    end

    // Purpose: register the count, the unlimited flag and the overflow pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            avail     <= '0;
            unlimited <= 1'b0;
            ovf       <= 1'b0;
        end else if (init_valid) begin
            avail     <= init_val;
            unlimited <= &init_val;
            ovf       <= 1'b0;
        end else begin
            ovf <= 1'b0;
            if (!unlimited) begin
                avail <= next_cnt;
                ovf   <= over;
            end
        end
    end
endmodule

// File: rtl/tx_credit_gate.sv
// Module: transmit flow gate for one traffic class, with a header pool and a
// data pool. Grants a waiting packet in the same cycle once both pools cover it.
// Assumes: the requester holds req_valid and its fields until grant.
module tx_credit_gate #(
    parameter int HDR_W  = txcg_pkg::HDR_W_DEF,
    parameter int DATA_W = txcg_pkg::DATA_W_DEF,
    parameter int LEN_W  = txcg_pkg::LEN_W_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              init_valid,
    input  logic [HDR_W-1:0]  init_hdr,
    input  logic [DATA_W-1:0] init_data,
    input  logic              upd_valid,
    input  logic [HDR_W-1:0]  upd_hdr,
    input  logic [DATA_W-1:0] upd_data,
    input  logic              req_valid,
    input  logic              req_has_data,
    input  logic [LEN_W-1:0]  req_len,
    output logic              grant,
    output logic              ovf_err
);
    localparam logic [HDR_W-1:0] ONE_HDR = HDR_W'(1);

    logic              link_q;
    logic [DATA_W-1:0] data_need;
    logic [HDR_W-1:0]  hdr_avail;
    logic [DATA_W-1:0] data_avail;
    logic              hdr_inf, data_inf, hdr_ok, data_ok, hdr_ovf, data_ovf;

    // Purpose: the gate opens on the first init message and stays open.
    always_ff @(posedge clk) begin
        if (!rst_n)
            link_q <= 1'b0;
        else if (init_valid)
            link_q <= 1'b1;
    end

    txcg_demand #(.LEN_W(LEN_W), .OUT_W(DATA_W)) demand_i (
        .len(req_len), .has_data(req_has_data), .need(data_need)
    );

    txcg_pool #(.W(HDR_W)) hdr_pool_i (
        .clk(clk), .rst_n(rst_n), .init_valid(init_valid), .init_val(init_hdr),
        .take(grant), .need(ONE_HDR), .ret_valid(upd_valid), .ret_amt(upd_hdr),
        .avail(hdr_avail), .unlimited(hdr_inf), .enough(hdr_ok), .ovf(hdr_ovf)
    );

    txcg_pool #(.W(DATA_W)) data_pool_i (
        .clk(clk), .rst_n(rst_n), .init_valid(init_valid), .init_val(init_data),
        .take(grant), .need(data_need), .ret_valid(upd_valid), .ret_amt(upd_data),
        .avail(data_avail), .unlimited(data_inf), .enough(data_ok), .ovf(data_ovf)
    );

    // Purpose: grant the packet only when the link is up, no init is in progress, and both pools cover it.
    assign grant   = req_valid && link_q && !init_valid && hdr_ok && data_ok;
    assign ovf_err = hdr_ovf || data_ovf;
endmodule

// File: rtl/txcg_checker.sv
// Module: assertion checker bound to tx_credit_gate.
// Assumes: the requester holds its request until grant.
module txcg_checker #(
    parameter int HDR_W  = 8,
    parameter int DATA_W = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              init_valid,
    input logic              upd_valid,
    input logic              req_valid,
    input logic              grant,
    input logic              link_up,
    input logic [HDR_W-1:0]  hdr_cnt,
    input logic              hdr_inf,
    input logic [DATA_W-1:0] data_cnt,
    input logic              data_inf,
    input logic              ovf_err
);
    p_no_grant_closed_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !link_up |-> !grant);
    p_link_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        link_up |=> link_up);
    p_grant_hdr_r3: assert property (@(posedge clk) disable iff (!rst_n)
        grant |-> (hdr_inf || hdr_cnt != '0));
    p_hdr_charge_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (grant && !hdr_inf && !upd_valid && !init_valid) |=> hdr_cnt == $past(hdr_cnt) - HDR_W'(1));
    p_hdr_unlimited_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (hdr_inf && !init_valid) |=> (hdr_inf && $stable(hdr_cnt)));
    p_data_unlimited_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (data_inf && !init_valid) |=> (data_inf && $stable(data_cnt)));
    p_err_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_err |-> $past(upd_valid));
    p_grant_req_r10: assert property (@(posedge clk) disable iff (!rst_n)
        grant |-> req_valid);
    p_init_block_r11: assert property (@(posedge clk) disable iff (!rst_n)
        init_valid |-> !grant);
endmodule

bind tx_credit_gate txcg_checker #(.HDR_W(HDR_W), .DATA_W(DATA_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .init_valid(init_valid), .upd_valid(upd_valid),
    .req_valid(req_valid), .grant(grant), .link_up(link_q),
    .hdr_cnt(hdr_avail), .hdr_inf(hdr_inf), .data_cnt(data_avail),
    .data_inf(data_inf), .ovf_err(ovf_err)
);

// File: tb/tx_credit_gate_tb.sv
module tx_credit_gate_tb_top;
    localparam int CLK_P = 10;
    localparam int HW = 8, DW = 12, LW = 10;
    localparam int HMAX = (1 << HW) - 1, DMAX = (1 << DW) - 1;

    logic clk = 1'b0, rst_n = 1'b0;
    logic init_valid = 1'b0, upd_valid = 1'b0, req_valid = 1'b0, req_has_data = 1'b0;
    logic [HW-1:0] init_hdr = '0, upd_hdr = '0;
    logic [DW-1:0] init_data = '0, upd_data = '0;
    logic [LW-1:0] req_len = '0;
    logic grant, ovf_err;

    int checks = 0, errors = 0;
    bit done = 1'b0;
    // reference model state
    int  m_h = 0, m_d = 0;
    bit  m_hi = 0, m_di = 0, m_link = 0, m_err = 0, last_g = 0;

    always #(CLK_P/2) clk = ~clk;

    tx_credit_gate #(.HDR_W(HW), .DATA_W(DW), .LEN_W(LW)) dut_i (
        .clk(clk), .rst_n(rst_n), .init_valid(init_valid), .init_hdr(init_hdr),
        .init_data(init_data), .upd_valid(upd_valid), .upd_hdr(upd_hdr),
        .upd_data(upd_data), .req_valid(req_valid), .req_has_data(req_has_data),
        .req_len(req_len), .grant(grant), .ovf_err(ovf_err)
    );

    function automatic int need_of(bit hasd, int len);
        if (!hasd) return 0;
        return (len == 0) ? 1024 : len;
    endfunction

    function automatic bit exp_grant(bit rq, bit iv, bit hasd, int len);
        return rq && m_link && !iv && (m_hi || m_h >= 1) && (m_di || m_d >= need_of(hasd, len));
    endfunction

    task automatic chk(string tag, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    // one cycle: drive, check grant and error, then advance the model at the edge
    task automatic step(bit iv, int ih, int id, bit uv, int uh, int ud,
                        bit rq, bit hasd, int len, string tag);
        bit g, e;
        int hs, ds;
        @(negedge clk);
        init_valid = iv; init_hdr = HW'(ih); init_data = DW'(id);
        upd_valid = uv; upd_hdr = HW'(uh); upd_data = DW'(ud);
        req_valid = rq; req_has_data = hasd; req_len = LW'(len);
        #1;
        g = exp_grant(rq, iv, hasd, len);
        chk(tag, "grant", int'(grant), int'(g));
        chk("R9", "ovf_err", int'(ovf_err), int'(m_err));
        last_g = g;
        @(posedge clk);
        e = 0;
        if (iv) begin
            m_h = ih; m_d = id; m_hi = (ih == HMAX); m_di = (id == DMAX); m_link = 1;
        end else begin
            if (!m_hi) begin
                hs = m_h - (g ? 1 : 0) + (uv ? uh : 0);
                if (hs > HMAX) begin m_h = HMAX; e = 1; end else m_h = hs;
            end
            if (!m_di) begin
                ds = m_d - (g ? need_of(hasd, len) : 0) + (uv ? ud : 0);
                if (ds > DMAX) begin m_d = DMAX; e = 1; end else m_d = ds;
            end
        end
        m_err = e;
    endtask

    initial begin : watchdog
        #(CLK_P * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired actual 0 expected 1");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : main
        bit pend, hasd, iv, uv;
        int len, ih, id, uh, ud;
        void'($urandom(32'd2718));
        repeat (3) @(negedge clk);
        #1;
        chk("R1", "grant in reset", int'(grant), 0);
        chk("R1", "ovf_err in reset", int'(ovf_err), 0);
        @(negedge clk); rst_n = 1'b1;
        // R1: no grant before init
        step(0,0,0, 0,0,0, 1,1,4, "R1");
        step(0,0,0, 0,0,0, 1,0,0, "R1");
        // R11: init cycle blocks grant; R2: open next cycle
        step(1,2,10, 0,0,0, 1,1,4, "R11");
        step(0,0,0, 0,0,0, 1,1,4, "R2");      // data 10 -> 6, hdr 2 -> 1
        step(0,0,0, 0,0,0, 1,1,7, "R10");     // 6 < 7 blocked
        step(0,0,0, 0,0,0, 1,0,9, "R6");      // no payload, hdr 1 -> 0
        step(0,0,0, 0,0,0, 1,0,0, "R3");      // header empty
        step(0,0,0, 1,1,4, 1,1,7, "R10");     // still blocked in return cycle
        step(0,0,0, 0,0,0, 1,1,7, "R8");      // 10 >= 7 granted
        step(0,0,0, 0,0,0, 1,0,0, "R4");      // hdr 0 after charge
        // R8: same-cycle return and grant
        step(0,0,0, 1,1,4, 1,1,3, "R8");
        step(0,0,0, 1,1,0, 1,1,5, "R8");      // hdr 1->... data 3+4=7? model decides
        // R5: zero length needs 1024
        step(1,4,1023, 0,0,0, 0,0,0, "R2");
        step(0,0,0, 0,0,0, 1,1,0, "R5");      // 1023 < 1024 blocked
        step(0,0,0, 1,0,1, 1,1,0, "R5");      // still blocked this cycle
        step(0,0,0, 0,0,0, 1,1,0, "R5");      // 1024 granted
        step(0,0,0, 0,0,0, 1,1,1, "R4");      // data now 0
        // R7: unlimited pools
        step(1,HMAX,DMAX, 0,0,0, 0,0,0, "R7");
        for (int i = 0; i < 300; i++)
            step(0,0,0, (i % 7) == 0, 3, 50, 1,1,0, "R7");
        // R9: overflow of a finite pool
        step(1,250,100, 0,0,0, 0,0,0, "R2");
        step(0,0,0, 1,10,0, 0,0,0, "R9");
        step(0,0,0, 0,0,0, 0,0,0, "R9");
        step(0,0,0, 1,0,DMAX, 0,0,0, "R9");
        step(0,0,0, 0,0,0, 1,1,0, "R9");
        // random phase: a pending request is held until the model grants it
        pend = 0; hasd = 0; len = 0;
        for (int i = 0; i < 4000; i++) begin
            if (!pend && ($urandom_range(0, 1) == 1)) begin
                pend = 1;
                hasd = ($urandom_range(0, 3) != 0);
                len  = ($urandom_range(0, 30) == 0) ? 0 : int'($urandom_range(1, 64));
            end
            iv = ($urandom_range(0, 250) == 0);
            ih = ($urandom_range(0, 5) == 0) ? HMAX : int'($urandom_range(0, 20));
            id = ($urandom_range(0, 5) == 0) ? DMAX : int'($urandom_range(0, 2000));
            uv = ($urandom_range(0, 3) == 0);
            uh = ($urandom_range(0, 80) == 0) ? HMAX : int'($urandom_range(0, 3));
            ud = ($urandom_range(0, 80) == 0) ? DMAX : int'($urandom_range(0, 80));
            step(iv, ih, id, uv, uh, ud, pend, hasd, len, "R3");
            if (last_g) pend = 0;
        end
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule